// File: doc/BRIEF.md
# Machine-Mode Trap CSR Unit

This block keeps the machine-level control and status registers of a small processor core that runs in two privilege levels, user and machine. It tracks the current privilege and the global interrupt enable, records where and why a trap happened, and supplies the program counter the front end must jump to when a trap is taken or a trap handler returns.

The status register carries a four-level history of (privilege, interrupt-enable) pairs. Taking a trap pushes (machine, disabled) onto that history and a return pops it, so handlers can be nested a few levels deep without software having to save the previous mode by hand. Besides the status register, the block holds the trap vector, a scratch word for the handler, the saved exception PC and the cause code. A CSR port gives machine-mode software read, write and atomic swap access. Any access from user mode, or to an address that decodes to no register, is refused and flagged so that the pipeline can raise an illegal-instruction trap.

The trap request, the return strobe and the CSR port are sampled on the same clock. The redirect outputs are combinational from the request so the fetch stage can steer in the same cycle. Register updates become visible on the next cycle.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset every history level holds (user = 2'b00, enabled = 1). So priv_o is 0, irq_en_o is 1, the status value reads 0x249 in its low 12 bits, the trap vector reads 0x100, and the exception PC, cause and scratch registers read 0.
- R2: Level n of the history sits at status bits [3n+2:3n+1] (privilege) and bit 3n (enable), and level 0 is the current state. A trap writes (machine = 2'b11, disabled = 0) into level 0, moves every level n up to level n+1, and loses the oldest level.
- R3: In the cycle trap_req_i is high, redirect_valid_o is 1 and redirect_pc_o equals the current trap vector. On the next edge the exception PC takes trap_pc_i itself, not the next instruction, and the cause register takes trap_cause_i (8 for a system call, 2 for an illegal instruction).
- R4: In a cycle in which ret_i is high, redirect_valid_o is 1 and redirect_pc_o equals the saved exception PC. On the next edge each level n takes level n+1, and the top level is refilled with (user, enabled).
- R5: When trap_req_i and ret_i are high in the same cycle, the trap alone takes effect. The redirect goes to the trap vector and the history is pushed, not popped.
- R6: The CSR addresses are 0x7C0 for status, 0x7C1 for the trap vector, 0x7C2 for scratch, 0x7C3 for the exception PC and 0x7C4 for cause. csr_op_i selects one of four operations: 0 reads the register; 1 writes csr_wdata_i and returns 0; 2 swaps, returning the old value while writing the new one; 3 behaves like a read. Written values show from the next cycle.
- R7: When csr_en_i is high in user mode, csr_illegal_o is 1 in the same cycle, csr_rdata_o is 0, and no register changes.
- R8: When csr_en_i is high in machine mode and the address is not one of the five listed in R6, csr_illegal_o is 1 and csr_rdata_o is 0.
- R9: When software writes the status register, each 2-bit privilege field is stored as 2'b00 if written as 2'b00 and as 2'b11 otherwise. Enable bits and the bits above bit 11 are stored as written.
- R10: A CSR write in a cycle with trap_req_i or ret_i high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_req_i | input | 1 | Take a trap this cycle |
| trap_cause_i | input | XLEN | Cause code of the trap |
| trap_pc_i | input | XLEN | PC of the faulting or interrupted instruction |
| ret_i | input | 1 | Return from trap this cycle |
| csr_en_i | input | 1 | CSR access request |
| csr_op_i | input | 2 | CSR operation: 0 read, 1 write, 2 swap, 3 read |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (0 unless a legal read or swap) |
| csr_illegal_o | output | 1 | Access refused, the pipeline should raise an illegal-instruction trap |
| redirect_valid_o | output | 1 | Fetch must redirect this cycle |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_o | output | 2 | Current privilege, 2'b00 user, 2'b11 machine |
| irq_en_o | output | 1 | Current global interrupt enable |

## Verification
The bench nests five traps to reach the point where the oldest history level falls off, then unwinds them one return at a time. A stack with the shift in the wrong direction, or one that keeps the oldest level, shows a wrong status word at some depth. It drives a trap and a return in the same cycle, and a CSR write together with a trap. A design that lets the return or the write win would pop the history or corrupt scratch. It also writes privilege fields with the reserved codes and attempts CSR writes from user mode. A missing legalization or a missing privilege check appears as a stray privilege value or a changed scratch register.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_SWAP  = 2'd2;

  localparam logic [11:0] ADDR_STATUS  = 12'h7C0;
  localparam logic [11:0] ADDR_TVEC    = 12'h7C1;
  localparam logic [11:0] ADDR_SCRATCH = 12'h7C2;
  localparam logic [11:0] ADDR_EPC     = 12'h7C3;
  localparam logic [11:0] ADDR_CAUSE   = 12'h7C4;

  localparam int unsigned CAUSE_SYSCALL = 8;
  localparam int unsigned CAUSE_ILLEGAL = 2;

  typedef struct packed {
    logic status;
    logic tvec;
    logic scratch;
    logic epc;
    logic cause;
  } csr_sel_t;

  function automatic logic [1:0] legal_priv(input logic [1:0] p);
    return (p == PRIV_U) ? PRIV_U : PRIV_M;
  endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import trap_csr_pkg::*;
(
  input  logic        en_i,
  input  logic [1:0]  op_i,
  input  logic [11:0] addr_i,
  input  logic [1:0]  priv_i,
  output csr_sel_t    sel_o,
  output logic        illegal_o,
  output logic        rd_en_o,
  output logic        wr_en_o
);

  logic hit;

  always_comb begin
    sel_o = '0;
    unique case (addr_i)
      ADDR_STATUS:  sel_o.status  = 1'b1;
      ADDR_TVEC:    sel_o.tvec    = 1'b1;
      ADDR_SCRATCH: sel_o.scratch = 1'b1;
      ADDR_EPC:     sel_o.epc     = 1'b1;
      ADDR_CAUSE:   sel_o.cause   = 1'b1;
      default:      sel_o         = '0;
    endcase
  end

  assign hit       = |sel_o;
  assign illegal_o = en_i && ((priv_i == PRIV_U) || !hit);
  assign rd_en_o   = en_i && !illegal_o && (op_i != OP_WRITE);
  assign wr_en_o   = en_i && !illegal_o && ((op_i == OP_WRITE) || (op_i == OP_SWAP));

endmodule

// File: rtl/priv_stack.sv
module priv_stack
  import trap_csr_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] status_o,
  output logic [1:0]      priv_o,
  output logic            ie_o
);

  localparam int unsigned LVL_W   = 3;
  localparam int unsigned STACK_W = DEPTH * LVL_W;
  localparam int unsigned OTHER_W = XLEN - STACK_W;

  logic [DEPTH-1:0][1:0] prv_q;
  logic [DEPTH-1:0]      ie_q;
  logic [OTHER_W-1:0]    other_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    logic [1:0] push_prv, pop_prv;
    logic       push_ie,  pop_ie;

    if (g == 0) begin : g_bottom
      assign push_prv = PRIV_M;
      assign push_ie  = 1'b0;
    end else begin : g_upper
      assign push_prv = prv_q[g-1];
      assign push_ie  = ie_q[g-1];
    end

    if (g == DEPTH - 1) begin : g_top
      assign pop_prv = PRIV_U;
      assign pop_ie  = 1'b1;
    end else begin : g_below
      assign pop_prv = prv_q[g+1];
      assign pop_ie  = ie_q[g+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prv_q[g] <= PRIV_U;
        ie_q[g]  <= 1'b1;
      end else if (push_i) begin
        prv_q[g] <= push_prv;
        ie_q[g]  <= push_ie;
      end else if (pop_i) begin
        prv_q[g] <= pop_prv;
        ie_q[g]  <= pop_ie;
      end else if (wr_i) begin
        prv_q[g] <= legal_priv(wdata_i[g*LVL_W+1 +: 2]);
        ie_q[g]  <= wdata_i[g*LVL_W];
      end
    end

    assign status_o[g*LVL_W +: LVL_W] = {prv_q[g], ie_q[g]};

    AST_LVL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prv_q[g] == PRIV_U) || (prv_q[g] == PRIV_M)); // R9
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   other_q <= '0;
    else if (wr_i) other_q <= wdata_i[XLEN-1:STACK_W];
  end

  assign status_o[XLEN-1:STACK_W] = other_q;
  assign priv_o = prv_q[0];
  assign ie_o   = ie_q[0];

  AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (prv_q[0] == PRIV_M) && !ie_q[0]); // R2
  AST_PUSH_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (prv_q[1] == $past(prv_q[0])) && (ie_q[1] == $past(ie_q[0]))); // R2
  AST_POP_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (prv_q[0] == $past(prv_q[1])) && (ie_q[0] == $past(ie_q[1]))); // R4
  AST_POP_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (prv_q[DEPTH-1] == PRIV_U) && ie_q[DEPTH-1]); // R4

endmodule

// File: rtl/csr_regs.sv
module csr_regs
  import trap_csr_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter logic [XLEN-1:0] TVEC_RESET = 'h100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic            wr_i,
  input  csr_sel_t        sel_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] tvec_o,
  output logic [XLEN-1:0] scratch_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tvec_o    <= TVEC_RESET;
      scratch_o <= '0;
    end else if (wr_i) begin
      if (sel_i.tvec)    tvec_o    <= wdata_i;
      if (sel_i.scratch) scratch_o <= wdata_i;
    end
  end

  // trap capture takes precedence over software writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o   <= '0;
      cause_o <= '0;
    end else if (trap_i) begin
      epc_o   <= trap_pc_i;
      cause_o <= trap_cause_i;
    end else if (wr_i) begin
      if (sel_i.epc)   epc_o   <= wdata_i;
      if (sel_i.cause) cause_o <= wdata_i;
    end
  end

  AST_EPC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> epc_o == $past(trap_pc_i)); // R3
  AST_CAUSE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> cause_o == $past(trap_cause_i)); // R3

endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
  import trap_csr_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned STACK_DEPTH = 4,
  parameter logic [XLEN-1:0] TVEC_RESET = 'h100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_req_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic            ret_i,
  input  logic            csr_en_i,
  input  logic [1:0]      csr_op_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [1:0]      priv_o,
  output logic            irq_en_o
);

  csr_sel_t        sel;
  logic            rd_en, wr_en, wr_ok, do_pop;
  logic [XLEN-1:0] status, tvec, scratch, epc, cause;

  csr_decode u_decode (
    .en_i      (csr_en_i),
    .op_i      (csr_op_i),
    .addr_i    (csr_addr_i),
    .priv_i    (priv_o),
    .sel_o     (sel),
    .illegal_o (csr_illegal_o),
    .rd_en_o   (rd_en),
    .wr_en_o   (wr_en)
  );

  // control-flow events own the cycle
  assign wr_ok  = wr_en && !trap_req_i && !ret_i;
  assign do_pop = ret_i && !trap_req_i;

  priv_stack #(.XLEN(XLEN), .DEPTH(STACK_DEPTH)) u_stack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (trap_req_i),
    .pop_i    (do_pop),
    .wr_i     (wr_ok && sel.status),
    .wdata_i  (csr_wdata_i),
    .status_o (status),
    .priv_o   (priv_o),
    .ie_o     (irq_en_o)
  );

  csr_regs #(.XLEN(XLEN), .TVEC_RESET(TVEC_RESET)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trap_i       (trap_req_i),
    .trap_pc_i    (trap_pc_i),
    .trap_cause_i (trap_cause_i),
    .wr_i         (wr_ok),
    .sel_i        (sel),
    .wdata_i      (csr_wdata_i),
    .tvec_o       (tvec),
    .scratch_o    (scratch),
    .epc_o        (epc),
    .cause_o      (cause)
  );

  always_comb begin
    csr_rdata_o = '0;
    if (rd_en) begin
      if (sel.status)  csr_rdata_o = status;
      if (sel.tvec)    csr_rdata_o = tvec;
      if (sel.scratch) csr_rdata_o = scratch;
      if (sel.epc)     csr_rdata_o = epc;
      if (sel.cause)   csr_rdata_o = cause;
    end
  end

  assign redirect_valid_o = trap_req_i || ret_i;
  assign redirect_pc_o    = trap_req_i ? tvec : (ret_i ? epc : '0);

  AST_TRAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i && ret_i) |=> (priv_o == PRIV_M) && !irq_en_o); // R5
  AST_USER_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_en_i && (priv_o == PRIV_U) && !trap_req_i && !ret_i)
      |=> $stable(scratch) && $stable(tvec) && $stable(status)); // R7
  AST_ILLEGAL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> csr_rdata_o == '0); // R8
  AST_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_en_i && trap_req_i) |=> $stable(scratch) && $stable(tvec)); // R10

endmodule

// File: tb/trap_csr_unit_tb.sv
module trap_csr_unit_tb;
  import trap_csr_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trap_req_i = 1'b0;
  logic [31:0] trap_cause_i = '0;
  logic [31:0] trap_pc_i = '0;
  logic        ret_i = 1'b0;
  logic        csr_en_i = 1'b0;
  logic [1:0]  csr_op_i = '0;
  logic [11:0] csr_addr_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        csr_illegal_o;
  logic        redirect_valid_o;
  logic [31:0] redirect_pc_o;
  logic [1:0]  priv_o;
  logic        irq_en_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk_i = ~clk_i;

  trap_csr_unit u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_trap(input logic [31:0] cause, input logic [31:0] pc, input logic [31:0] exp_pc);
    trap_req_i = 1'b1; trap_cause_i = cause; trap_pc_i = pc;
    #1;
    check("R3 trap redirect valid", 32'(redirect_valid_o), 32'd1);
    check("R3 trap redirect pc", redirect_pc_o, exp_pc);
    step();
    trap_req_i = 1'b0;
  endtask

  task automatic do_ret(input logic [31:0] exp_pc);
    ret_i = 1'b1;
    #1;
    check("R4 ret redirect valid", 32'(redirect_valid_o), 32'd1);
    check("R4 ret redirect pc", redirect_pc_o, exp_pc);
    step();
    ret_i = 1'b0;
  endtask

  task automatic csr_access(input logic [1:0] op, input logic [11:0] addr,
                            input logic [31:0] wdata, output logic [31:0] rdata,
                            output logic illegal);
    csr_en_i = 1'b1; csr_op_i = op; csr_addr_i = addr; csr_wdata_i = wdata;
    #1;
    rdata = csr_rdata_o;
    illegal = csr_illegal_o;
    step();
    csr_en_i = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [11:0] addr, input logic [31:0] exp);
    logic [31:0] d;
    logic        ill;
    csr_access(OP_READ, addr, '0, d, ill);
    check(tag, d, exp);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic        ill;
    check("R1 reset priv", 32'(priv_o), 32'd0);
    check("R1 reset irq_en", 32'(irq_en_o), 32'd1);
    check("R1 reset no redirect", 32'(redirect_valid_o), 32'd0);
    csr_access(OP_READ, ADDR_STATUS, '0, d, ill);
    check("R7 user read illegal", 32'(ill), 32'd1);
    check("R7 user read data zero", d, 32'd0);
  endtask

  task automatic t_trap_entry();
    do_trap(CAUSE_SYSCALL, 32'h40, 32'h100);
    check("R2 trap priv machine", 32'(priv_o), 32'd3);
    check("R2 trap irq disabled", 32'(irq_en_o), 32'd0);
    rd_check("R2 status after one trap", ADDR_STATUS, 32'h24E);
    rd_check("R3 epc is faulting pc", ADDR_EPC, 32'h40);
    rd_check("R3 cause syscall", ADDR_CAUSE, 32'd8);
    rd_check("R1 tvec reset", ADDR_TVEC, 32'h100);
    rd_check("R1 scratch reset", ADDR_SCRATCH, 32'h0);
  endtask

  task automatic t_nesting();
    do_trap(CAUSE_ILLEGAL, 32'h104, 32'h100);
    rd_check("R2 status depth 2", ADDR_STATUS, 32'h276);
    do_trap(CAUSE_ILLEGAL, 32'h108, 32'h100);
    rd_check("R2 status depth 3", ADDR_STATUS, 32'h3B6);
    do_trap(CAUSE_ILLEGAL, 32'h10C, 32'h100);
    rd_check("R2 status depth 4", ADDR_STATUS, 32'hDB6);
    do_trap(CAUSE_ILLEGAL, 32'h110, 32'h100);
    rd_check("R2 oldest level dropped", ADDR_STATUS, 32'hDB6);
    rd_check("R3 epc latest", ADDR_EPC, 32'h110);
    rd_check("R3 cause illegal", ADDR_CAUSE, 32'd2);
  endtask

  task automatic t_return();
    do_ret(32'h110);
    rd_check("R4 pop refill top", ADDR_STATUS, 32'h3B6);
    do_ret(32'h110);
    rd_check("R4 pop depth 2", ADDR_STATUS, 32'h276);
    do_ret(32'h110);
    rd_check("R4 pop depth 1", ADDR_STATUS, 32'h24E);
    do_ret(32'h110);
    check("R4 back to user priv", 32'(priv_o), 32'd0);
    check("R4 back to user irq", 32'(irq_en_o), 32'd1);
  endtask

  task automatic t_csr_ops();
    logic [31:0] d;
    logic        ill;
    do_trap(CAUSE_SYSCALL, 32'h200, 32'h100);
    csr_access(OP_WRITE, ADDR_SCRATCH, 32'hDEADBEEF, d, ill);
    check("R6 write returns zero", d, 32'h0);
    check("R6 write legal in machine", 32'(ill), 32'd0);
    rd_check("R6 scratch written", ADDR_SCRATCH, 32'hDEADBEEF);
    csr_access(OP_SWAP, ADDR_SCRATCH, 32'h12345678, d, ill);
    check("R6 swap returns old", d, 32'hDEADBEEF);
    rd_check("R6 swap stored new", ADDR_SCRATCH, 32'h12345678);
    csr_access(2'd3, ADDR_SCRATCH, 32'hFFFFFFFF, d, ill);
    check("R6 op3 reads", d, 32'h12345678);
    rd_check("R6 op3 no write", ADDR_SCRATCH, 32'h12345678);
    csr_access(OP_WRITE, ADDR_TVEC, 32'h300, d, ill);
    csr_access(OP_WRITE, ADDR_EPC, 32'h444, d, ill);
    csr_access(OP_WRITE, ADDR_CAUSE, 32'h5, d, ill);
    rd_check("R6 cause writable", ADDR_CAUSE, 32'h5);
    do_ret(32'h444);
    check("R4 ret to user", 32'(priv_o), 32'd0);
    do_trap(CAUSE_ILLEGAL, 32'h50, 32'h300);
  endtask

  task automatic t_unknown();
    logic [31:0] d;
    logic        ill;
    csr_access(OP_READ, 12'h7C9, '0, d, ill);
    check("R8 unknown addr illegal", 32'(ill), 32'd1);
    check("R8 unknown addr data zero", d, 32'h0);
  endtask

  task automatic t_legalize();
    logic [31:0] d;
    logic        ill;
    csr_access(OP_WRITE, ADDR_STATUS, 32'hA5A50003, d, ill);
    rd_check("R9 priv 01 stored as 11", ADDR_STATUS, 32'hA5A50007);
    check("R9 priv output machine", 32'(priv_o), 32'd3);
    check("R9 enable as written", 32'(irq_en_o), 32'd1);
  endtask

  task automatic t_trap_ret_same();
    trap_req_i = 1'b1; ret_i = 1'b1;
    trap_cause_i = CAUSE_ILLEGAL; trap_pc_i = 32'h60;
    #1;
    check("R5 redirect to tvec", redirect_pc_o, 32'h300);
    step();
    trap_req_i = 1'b0; ret_i = 1'b0;
    rd_check("R5 history pushed", ADDR_STATUS, 32'hA5A5003E);
    rd_check("R5 epc captured", ADDR_EPC, 32'h60);
  endtask

  task automatic t_write_on_trap();
    csr_en_i = 1'b1; csr_op_i = OP_WRITE; csr_addr_i = ADDR_SCRATCH;
    csr_wdata_i = 32'hFFFF0000;
    do_trap(CAUSE_SYSCALL, 32'h70, 32'h300);
    csr_en_i = 1'b0;
    rd_check("R10 write dropped on trap", ADDR_SCRATCH, 32'h12345678);
  endtask

  task automatic t_user_reject();
    logic [31:0] d;
    logic        ill;
    csr_access(OP_WRITE, ADDR_STATUS, 32'h00000006, d, ill);
    do_ret(32'h70);
    check("R4 restored user priv", 32'(priv_o), 32'd0);
    check("R4 restored irq disabled", 32'(irq_en_o), 32'd0);
    csr_access(OP_WRITE, ADDR_SCRATCH, 32'h0000AAAA, d, ill);
    check("R7 user write illegal", 32'(ill), 32'd1);
    do_trap(CAUSE_SYSCALL, 32'h80, 32'h300);
    rd_check("R7 user write had no effect", ADDR_SCRATCH, 32'h12345678);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_trap_entry();
    t_nesting();
    t_return();
    t_csr_ops();
    t_unknown();
    t_legalize();
    t_trap_ret_same();
    t_write_on_trap();
    t_user_reject();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule